// File: doc/BRIEF.md
# Parity-Protected Instruction Queue with Deferred Error Tagging

This block is an in-order instruction queue that sits between fetch and issue. Each stored slot holds an instruction word and its fetch PC. It also holds an error-neutral flag, derived at enqueue from a two-bit opcode class, and one even-parity bit that covers the word and the flag together. When the oldest slot issues, the block recomputes parity. A mismatch does not stop the machine. It turns into a "suspect" tag that leaves the queue with the instruction. The tag is left clear when the flag read back from storage marks the instruction as error-neutral.

A separate commit port takes the suspect tag back once the instruction retires, together with a wrong-path marker. A machine-check pulse is raised only for a valid, tagged, correct-path commit. Instructions that were squashed or predicated off therefore never stop the machine.

To shorten the time instructions sit in unprotected storage, the issue port accepts a load-miss marker alongside the issuing instruction. An issuing load that misses discards every slot behind it. The PC of the first discarded instruction is reported so that fetch can fetch it again from the protected instruction cache. A fault-injection port flips any single stored bit, so that soft errors can be exercised at the block's edge.

Top module: `iq_poison_queue`

## Requirements
- R1: After synchronous active-low reset the queue is empty. `issue_valid`, `machine_check` and `refetch_valid` are 0 and `enq_ready` is 1.
- R2: Instructions leave in enqueue order, each with its own PC. Once DEPTH slots are held, `enq_ready` is 0.
- R3: `enq_class` encodes 0 = ordinary, 1 = no-op, 2 = prefetch, 3 = branch hint. Every nonzero class stores the error-neutral flag as 1.
- R4: The parity bit is even parity over the instruction word and the flag. If the read-back parity mismatches and the read-back flag is 0, `issue_tag` is 1 in the issuing cycle. Issue never raises `machine_check` by itself.
- R5: If the read-back parity mismatches and the read-back flag is 1, `issue_tag` is 0. This includes a flipped flag bit on an ordinary instruction.
- R6: With no mismatch, `issue_tag` is 0.
- R7: `machine_check` is 1 for exactly the cycle after a commit with `cmt_valid`=1, `cmt_tag`=1 and `cmt_wrong_path`=0. Otherwise it is 0.
- R8: An issue with `issue_miss`=1 leaves the queue empty on the next cycle, and `enq_ready` is 0 in that cycle. If at least one slot stood behind the load, `refetch_valid` is 1 in that cycle and `refetch_pc` is the PC of the slot right behind the load. Otherwise `refetch_valid` is 0.
- R9: `inj_valid` flips one stored bit of slot `inj_slot`. `inj_bit` values 0..DATA_W-1 select instruction bits, DATA_W selects the flag and DATA_W+1 selects the parity bit. A flipped parity bit on its own gives a mismatch.
- R10: After a squash, new enqueues are stored and issue in order as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | Enqueue request |
| enq_instr | input | DATA_W | Instruction word to store |
| enq_pc | input | PC_W | Fetch PC of the instruction |
| enq_class | input | 2 | Opcode class (0 ordinary, 1 no-op, 2 prefetch, 3 hint) |
| enq_ready | output | 1 | Enqueue accepted this cycle when high |
| issue_ready | input | 1 | Downstream takes the oldest slot |
| issue_miss | input | 1 | Issuing load missed in the L1 data cache |
| issue_valid | output | 1 | Oldest slot is present |
| issue_instr | output | DATA_W | Instruction word of the oldest slot |
| issue_pc | output | PC_W | PC of the oldest slot |
| issue_tag | output | 1 | Suspect tag for the issuing instruction |
| refetch_valid | output | 1 | Squash discarded at least one slot |
| refetch_pc | output | PC_W | PC of the first discarded instruction |
| cmt_valid | input | 1 | Commit of one instruction |
| cmt_wrong_path | input | 1 | Committing instruction is wrong-path or predicated off |
| cmt_tag | input | 1 | Suspect tag carried to commit |
| machine_check | output | 1 | Error pulse, one per offending commit |
| inj_valid | input | 1 | Fault injection strobe |
| inj_slot | input | $clog2(DEPTH) | Slot to corrupt |
| inj_bit | input | $clog2(DATA_W+2) | Bit within the slot's protected word |

## Verification
A corrupted slot, or a wrong head or tail pointer, shows up at the ports in the cycle that slot reaches the head. It appears as a wrong instruction or PC, or as a suspect tag that disagrees with the flipped bit and the class of that instruction. A wrong occupancy count shows sooner. `enq_ready` then falls at the wrong fill level, or `issue_valid` stays high after a squash, one cycle after the squashing issue. A fault in the commit judgement is seen one cycle after the offending commit, on `machine_check`.

// File: rtl/iqp_pkg.sv
// Package: shared opcode-class encoding and the parity helper for the
// poison-tracking instruction queue. Assumes even parity.
package iqp_pkg;

    typedef enum logic [1:0] {
        OPC_PLAIN    = 2'd0,
        OPC_NOP      = 2'd1,
        OPC_PREFETCH = 2'd2,
        OPC_HINT     = 2'd3
    } opc_class_e;

    // Error-neutral instruction types are every class except ordinary.
    function automatic logic class_is_neutral(input logic [1:0] cls);
        return cls != OPC_PLAIN;
    endfunction

endpackage

// File: rtl/iqp_storage.sv
// Slot storage: DEPTH slots, each holding {parity, flag, instruction}
// plus an unprotected PC. One write port, one fault-injection port and
// two read ports (head slot and the slot behind head).
// Assumes a write and an injection never target the same slot together;
// if they do, the write wins.
module iqp_storage #(
    parameter int DATA_W = 32,
    parameter int PC_W   = 32,
    parameter int DEPTH  = 16,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int WORD_W = DATA_W + 2,
    localparam int BIT_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_instr,
    input  logic              wr_flag,
    input  logic              wr_par,
    input  logic [PC_W-1:0]   wr_pc,
    input  logic              inj_en,
    input  logic [PTR_W-1:0]  inj_idx,
    input  logic [BIT_W-1:0]  inj_bit,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_instr,
    output logic              rd_flag,
    output logic              rd_par,
    output logic [PC_W-1:0]   rd_pc,
    input  logic [PTR_W-1:0]  rd2_idx,
    output logic [PC_W-1:0]   rd2_pc
);
    logic [WORD_W-1:0] word_q [DEPTH];
    logic [PC_W-1:0]   pc_q   [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        // Per-slot update: reset clear, then write, then single-bit flip.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[s] <= '0;
                pc_q[s]   <= '0;
            end else if (wr_en && wr_idx == PTR_W'(s)) begin
                word_q[s] <= {wr_par, wr_flag, wr_instr};
                pc_q[s]   <= wr_pc;
            end else if (inj_en && inj_idx == PTR_W'(s) && int'(inj_bit) < WORD_W) begin
                word_q[s][inj_bit] <= ~word_q[s][inj_bit];
            end
        end
    end

    // Head read: unpack the protected word.
    always_comb begin
        rd_instr = word_q[rd_idx][DATA_W-1:0];
        rd_flag  = word_q[rd_idx][DATA_W];
        rd_par   = word_q[rd_idx][DATA_W+1];
        rd_pc    = pc_q[rd_idx];
        rd2_pc   = pc_q[rd2_idx];
    end
endmodule

// File: rtl/iqp_ptr_ctrl.sv
// Head/tail/occupancy control for the circular queue. A squash keeps
// only the issuing slot's successor position as the new tail and leaves
// the queue empty. Assumes the caller blocks enqueue while full or
// squashing, and only dequeues when not empty.
module iqp_ptr_ctrl #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_fire,
    input  logic             deq_fire,
    input  logic             squash,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] head_nxt,
    output logic [PTR_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    // Wrap-around increment that works for any depth.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        head_nxt = bump(head);
        full     = (count == CNT_W'(DEPTH));
        empty    = (count == '0);
    end

    // Pointer and occupancy update; squash takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else if (squash) begin
            head  <= head_nxt;
            tail  <= head_nxt;
            count <= '0;
        end else begin
            if (enq_fire) tail <= bump(tail);
            if (deq_fire) head <= head_nxt;
            if (enq_fire && !deq_fire)      count <= count + 1'b1;
            else if (!enq_fire && deq_fire) count <= count - 1'b1;
        end
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enq_fire |-> (count < CNT_W'(DEPTH)));
    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deq_fire |-> (count != '0));
    // R8
    squash_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> (count == '0) && (head == tail));
    // R2
    deq_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_fire && !enq_fire && !squash) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/iqp_parity_check.sv
// Issue-side parity check: recomputes even parity over the read-back
// instruction and flag, and converts a mismatch into a suspect tag unless
// the read-back flag marks the instruction error-neutral. Purely
// combinational; assumes the inputs come straight from storage.
module iqp_parity_check #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] instr,
    input  logic              flag,
    input  logic              par,
    input  logic              valid,
    output logic              tag
);
    logic mismatch;

    // Parity recompute and neutral masking.
    always_comb begin
        mismatch = ^{par, flag, instr};
        tag      = valid && mismatch && !flag;
    end
endmodule

// File: rtl/iqp_commit_judge.sv
// Commit-side error decision: raises a one-cycle machine-check pulse for
// a valid, tagged commit that is on the correct path. Assumes at most one
// commit per cycle.
module iqp_commit_judge (
    input  logic clk,
    input  logic rst_n,
    input  logic cmt_valid,
    input  logic cmt_wrong_path,
    input  logic cmt_tag,
    output logic machine_check
);
    // Register the decision so the pulse lasts exactly one cycle per commit.
    always_ff @(posedge clk) begin
        if (!rst_n) machine_check <= 1'b0;
        else        machine_check <= cmt_valid && cmt_tag && !cmt_wrong_path;
    end

    // R7
    wrong_path_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && cmt_wrong_path) |=> !machine_check);
    // R7
    idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmt_valid |=> !machine_check);
endmodule

// File: rtl/iq_poison_queue.sv
// Top: parity-protected in-order instruction queue with deferred error
// tagging and load-miss squash. The error-neutral flag is derived from
// the opcode class at enqueue and shares the instruction's parity bit.
// Assumes downstream presents issue_miss only for an issuing load.
module iq_poison_queue #(
    parameter int DATA_W = 32,
    parameter int PC_W   = 32,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int BIT_W = $clog2(DATA_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    input  logic [DATA_W-1:0] enq_instr,
    input  logic [PC_W-1:0]   enq_pc,
    input  logic [1:0]        enq_class,
    output logic              enq_ready,
    input  logic              issue_ready,
    input  logic              issue_miss,
    output logic              issue_valid,
    output logic [DATA_W-1:0] issue_instr,
    output logic [PC_W-1:0]   issue_pc,
    output logic              issue_tag,
    output logic              refetch_valid,
    output logic [PC_W-1:0]   refetch_pc,
    input  logic              cmt_valid,
    input  logic              cmt_wrong_path,
    input  logic              cmt_tag,
    output logic              machine_check,
    input  logic              inj_valid,
    input  logic [PTR_W-1:0]  inj_slot,
    input  logic [BIT_W-1:0]  inj_bit
);
    logic             full, empty, enq_fire, issue_fire, squash;
    logic             wr_flag, wr_par, rd_flag, rd_par;
    logic [PTR_W-1:0] head, head_nxt, tail;
    logic [CNT_W-1:0] count;

    // Handshake decode: squash blocks enqueue for its cycle.
    always_comb begin
        issue_valid   = !empty;
        issue_fire    = issue_valid && issue_ready;
        squash        = issue_fire && issue_miss;
        enq_ready     = !full && !squash;
        enq_fire      = enq_valid && enq_ready;
        wr_flag       = iqp_pkg::class_is_neutral(enq_class);
        wr_par        = ^{wr_flag, enq_instr};
        refetch_valid = squash && (count > CNT_W'(1));
    end

    iqp_ptr_ctrl #(.DEPTH(DEPTH)) ptr_i (
        .clk(clk), .rst_n(rst_n),
        .enq_fire(enq_fire), .deq_fire(issue_fire), .squash(squash),
        .head(head), .head_nxt(head_nxt), .tail(tail), .count(count),
        .full(full), .empty(empty)
    );

    iqp_storage #(.DATA_W(DATA_W), .PC_W(PC_W), .DEPTH(DEPTH)) store_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(enq_fire), .wr_idx(tail), .wr_instr(enq_instr),
        .wr_flag(wr_flag), .wr_par(wr_par), .wr_pc(enq_pc),
        .inj_en(inj_valid), .inj_idx(inj_slot), .inj_bit(inj_bit),
        .rd_idx(head), .rd_instr(issue_instr), .rd_flag(rd_flag),
        .rd_par(rd_par), .rd_pc(issue_pc),
        .rd2_idx(head_nxt), .rd2_pc(refetch_pc)
    );

    iqp_parity_check #(.DATA_W(DATA_W)) chk_i (
        .instr(issue_instr), .flag(rd_flag), .par(rd_par),
        .valid(issue_valid), .tag(issue_tag)
    );

    iqp_commit_judge judge_i (
        .clk(clk), .rst_n(rst_n),
        .cmt_valid(cmt_valid), .cmt_wrong_path(cmt_wrong_path),
        .cmt_tag(cmt_tag), .machine_check(machine_check)
    );

    // R4
    tag_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_tag |-> issue_valid);
    // R8
    refetch_then_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refetch_valid |=> !issue_valid);
    // R2
    full_blocks_enq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_W'(DEPTH)) |-> !enq_ready);
endmodule

// File: tb/iq_poison_queue_tb_top.sv
// Scoreboard bench: the enqueue driver pushes expected slots, and the
// monitor pops and compares them on every issue.
module iq_poison_queue_tb_top;
    localparam int DW = 32;
    localparam int PW = 32;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enq_valid = 0, issue_ready = 0, issue_miss = 0;
    logic cmt_valid = 0, cmt_wrong_path = 0, cmt_tag = 0, inj_valid = 0;
    logic [DW-1:0] enq_instr = '0;
    logic [PW-1:0] enq_pc = '0;
    logic [1:0] enq_class = '0;
    logic [3:0] inj_slot = '0;
    logic [5:0] inj_bit = '0;
    logic enq_ready, issue_valid, issue_tag, refetch_valid, machine_check;
    logic [DW-1:0] issue_instr;
    logic [PW-1:0] issue_pc, refetch_pc;

    always #2 clk = ~clk;

    iq_poison_queue dut_i (.*);

    typedef struct {
        logic [DW-1:0] instr;
        logic [PW-1:0] pc;
        logic flag;
        logic par;
        int slot;
    } exp_t;
    exp_t sbq[$];
    int tb_tail = 0;
    int errors = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        enq_valid = 0; issue_ready = 0; issue_miss = 0;
        cmt_valid = 0; cmt_wrong_path = 0; cmt_tag = 0; inj_valid = 0;
    endtask

    // Driver: one enqueue, pushing the expected slot contents.
    task automatic enq(input logic [DW-1:0] ins, input logic [PW-1:0] pc, input logic [1:0] cls);
        exp_t e;
        @(posedge clk); #1; idle();
        enq_valid = 1; enq_instr = ins; enq_pc = pc; enq_class = cls;
        e.instr = ins; e.pc = pc; e.flag = (cls != 2'd0);
        e.par = ^{e.flag, ins}; e.slot = tb_tail;
        sbq.push_back(e);
        tb_tail = (tb_tail + 1) % DEPTH;
    endtask

    task automatic issue(input logic miss);
        @(posedge clk); #1; idle();
        issue_ready = 1; issue_miss = miss;
    endtask

    task automatic inject(input int slot, input int b);
        @(posedge clk); #1; idle();
        inj_valid = 1; inj_slot = slot[3:0]; inj_bit = b[5:0];
        foreach (sbq[i]) if (sbq[i].slot == slot) begin
            if (b < DW) sbq[i].instr[b] = ~sbq[i].instr[b];
            else if (b == DW) sbq[i].flag = ~sbq[i].flag;
            else sbq[i].par = ~sbq[i].par;
        end
    endtask

    task automatic settle();
        @(posedge clk); #1; idle();
        @(negedge clk);
    endtask

    task automatic commit(input logic wp, input logic tg, input logic v, input logic exp_mc);
        @(posedge clk); #1; idle();
        cmt_valid = v; cmt_wrong_path = wp; cmt_tag = tg;
        @(posedge clk); #1; idle();
        @(negedge clk);
        chk(machine_check == exp_mc, "R7 machine_check after commit", machine_check, exp_mc);
    endtask

    // Monitor: compare each issued slot against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && issue_valid && issue_ready) begin
            if (sbq.size() == 0) begin
                chk(0, "R2 unexpected issue", issue_pc, 0);
            end else begin
                exp_t e;
                logic et;
                e = sbq.pop_front();
                et = (^{e.par, e.flag, e.instr}) & ~e.flag;
                chk(issue_instr == e.instr, "R2 issue_instr order", issue_instr, e.instr);
                chk(issue_pc == e.pc, "R2 issue_pc order", issue_pc, e.pc);
                chk(issue_tag == et, "R4/R5/R6 issue_tag", issue_tag, et);
                if (issue_miss) begin
                    chk(enq_ready == 0, "R8 enq_ready low in squash", enq_ready, 0);
                    chk(refetch_valid == (sbq.size() > 0), "R8 refetch_valid",
                        refetch_valid, sbq.size() > 0);
                    if (sbq.size() > 0)
                        chk(refetch_pc == sbq[0].pc, "R8 refetch_pc", refetch_pc, sbq[0].pc);
                    sbq.delete();
                    tb_tail = (e.slot + 1) % DEPTH;
                end else begin
                    chk(refetch_valid == 0, "R8 no refetch without miss", refetch_valid, 0);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(issue_valid == 0, "R1 issue_valid", issue_valid, 0);
        chk(enq_ready == 1, "R1 enq_ready", enq_ready, 1);
        chk(machine_check == 0, "R1 machine_check", machine_check, 0);
        chk(refetch_valid == 0, "R1 refetch_valid", refetch_valid, 0);

        // R2/R6: plain traffic, clean parity
        for (int i = 0; i < 4; i++) enq(32'hA000_0000 + i, 32'h100 + 4 * i, 2'd0);
        for (int i = 0; i < 4; i++) issue(0);
        settle();
        chk(issue_valid == 0, "R2 drained", issue_valid, 0);

        // R2: fill to depth
        for (int i = 0; i < DEPTH; i++) enq(32'h5A5A_0000 ^ (i * 32'h1357), 32'h2000 + 4 * i, i[1:0]);
        settle();
        chk(enq_ready == 0, "R2 enq_ready low when full", enq_ready, 0);
        for (int i = 0; i < DEPTH; i++) issue(0);
        settle();

        // R3/R4/R5/R9: fault injection against classes
        enq(32'h1111_0001, 32'h3000, 2'd0);  // ordinary, data flip -> tag
        enq(32'h1111_0002, 32'h3004, 2'd1);  // no-op, data flip -> no tag
        enq(32'h1111_0003, 32'h3008, 2'd0);  // ordinary, flag flip -> no tag
        enq(32'h1111_0004, 32'h300C, 2'd2);  // prefetch, flag flip -> tag
        enq(32'h1111_0005, 32'h3010, 2'd0);  // ordinary, parity flip -> tag (R9)
        enq(32'h1111_0006, 32'h3014, 2'd3);  // hint, untouched
        inject(sbq[0].slot, 3);
        inject(sbq[1].slot, 5);
        inject(sbq[2].slot, DW);
        inject(sbq[3].slot, DW);
        inject(sbq[4].slot, DW + 1);
        for (int i = 0; i < 6; i++) issue(0);
        settle();
        // R4: tagged issues alone never raise machine_check
        chk(machine_check == 0, "R4 no machine_check at issue", machine_check, 0);

        // R7: commit decisions
        commit(0, 1, 1, 1);
        commit(1, 1, 1, 0);
        commit(0, 0, 1, 0);
        commit(0, 1, 0, 0);
        commit(0, 1, 1, 1);
        @(negedge clk);
        chk(machine_check == 0, "R7 pulse one cycle", machine_check, 0);

        // R8: squash behind a missing load
        enq(32'hB000_0000, 32'h4000, 2'd0);
        enq(32'hB000_0001, 32'h4004, 2'd0);  // load
        enq(32'hB000_0002, 32'h4008, 2'd0);
        enq(32'hB000_0003, 32'h400C, 2'd0);
        enq(32'hB000_0004, 32'h4010, 2'd0);
        issue(0);
        issue(1);
        settle();
        chk(issue_valid == 0, "R8 empty after squash", issue_valid, 0);

        // R10: normal traffic after squash
        enq(32'hC000_0000, 32'h5000, 2'd0);
        enq(32'hC000_0001, 32'h5004, 2'd1);
        inject(sbq[0].slot, 7);
        issue(0);
        issue(0);
        settle();
        chk(issue_valid == 0, "R10 drained after squash", issue_valid, 0);

        // R8: squash with nothing behind the load
        enq(32'hD000_0000, 32'h6000, 2'd0);
        issue(1);
        settle();
        chk(issue_valid == 0, "R8 lone load squash empty", issue_valid, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule